// File: doc/BRIEF.md
# External Clock Failure Monitor

This block watches the frequency of an external clock that a PWM generator may use as its time base. While the external clock source is selected and PWM is enabled, it synchronises the external clock into the system clock domain. It then counts rising edges over a fixed window of system clock cycles and compares the count with a lower and an upper edge limit. A count outside the limits is a clock failure. A window with no edges at all, as from a stuck clock, counts as too slow.

On a failure the block stops passing external clock ticks to the PWM logic, pulls an active-low fault line low and sets a sticky clock-fail status bit. Each channel output then follows that channel's static on bit instead of the PWM waveform. To leave the failure, software must read the status bit (a one-cycle read strobe). After that read, one complete measurement window must come out in range. If that window is out of range, the block fails again and sets the status bit again.

The controller has four states. MON_IDLE: monitoring is off. MON_WATCH: monitoring, no fault. MON_FAIL: fault, waiting for a status read. MON_CONFIRM: fault, measuring one window after the read. The transitions are:
- Any state goes to MON_IDLE whenever monitoring is disabled.
- MON_IDLE goes to MON_WATCH once monitoring is enabled, and the window restarts.
- MON_WATCH goes to MON_FAIL when a window ends out of range.
- MON_FAIL goes to MON_CONFIRM on a read strobe, and the window restarts.
- MON_CONFIRM goes to MON_WATCH when a window ends in range, or to MON_FAIL when it ends out of range.

Top module: `extclk_monitor`

## Requirements
- R1: When ext_sel or pwm_on is low, no failure is flagged: fault_n is high (from the next cycle on), the sticky bit is not set, and ch_out equals pwm_wave.
- R2: With monitoring enabled, a window of WIN_CYCLES system cycles holding fewer than MIN_EDGES synchronised rising edges is a failure. This includes a window with zero edges.
- R3: With monitoring enabled, a window holding more than MAX_EDGES rising edges is a failure.
- R4: A clock whose edge count stays within MIN_EDGES..MAX_EDGES in every window never causes a failure.
- R5: While fault_n is low, ext_tick stays low. Otherwise ext_tick pulses once per synchronised external rising edge.
- R6: clk_fail_stat is set (value 1) when a failure is detected. It stays 1 until a cycle with stat_rd high, which clears it unless a new failure is detected in that same cycle.
- R7: While fault_n is low, ch_out[i] equals on_bit[i] for each channel. Otherwise ch_out[i] equals pwm_wave[i].
- R8: An in-range clock alone does not end a failure. fault_n stays low until stat_rd has been asserted.
- R9: After the read, fault_n stays low for one full window. It is released only if that window is in range; otherwise the failure is detected again and clk_fail_stat returns to 1.
- R10: After reset, fault_n is high, clk_fail_stat is 0 and ch_out follows pwm_wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External PWM clock, asynchronous to clk |
| ext_sel | input | 1 | External clock source selected |
| pwm_on | input | 1 | PWM generation enabled |
| stat_rd | input | 1 | One-cycle strobe: status bit has been read |
| on_bit | input | N_CH | Static on bit per channel |
| pwm_wave | input | N_CH | PWM waveform per channel |
| ext_tick | output | 1 | Synchronised external rising-edge pulse for the PWM logic |
| ch_out | output | N_CH | Channel drive |
| fault_n | output | 1 | Active-low clock fault |
| clk_fail_stat | output | 1 | Sticky clock-fail status bit |

## Verification
The bench drives the external clock at in-range, slow, fast and stopped rates. It checks that the stopped clock is reported as a failure, which a design that only compared against the upper limit would miss. It applies a good clock without a read and expects the fault to persist; a design that recovered on frequency alone would release early. After a read it samples fault_n part-way through the confirmation window, which catches a release before a complete window. A read made while the clock is still bad must leave the status bit set again. Disabling PWM during a fault must release fault_n but keep the sticky bit.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

    typedef enum logic [1:0] {
        MON_IDLE    = 2'd0,
        MON_WATCH   = 2'd1,
        MON_FAIL    = 2'd2,
        MON_CONFIRM = 2'd3
    } mon_state_t;

    typedef struct packed {
        logic done;
        logic slow;
        logic fast;
    } win_verdict_t;

endpackage

// File: rtl/extclk_sync.sv
module extclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = (STAGES < 2) ? 3 : STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], async_in};
        end
    end

    assign rise = chain[DEPTH-2] & ~chain[DEPTH-1];
endmodule

// File: rtl/extclk_window.sv
module extclk_window
    import extclk_pkg::*;
#(
    parameter int WIN_CYCLES = 64,
    parameter int MIN_EDGES  = 4,
    parameter int MAX_EDGES  = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic         edge_pulse,
    output win_verdict_t verdict
);
    localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam int EW = $clog2(MAX_EDGES + 2);
    localparam logic [CW-1:0] LAST_V = CW'(WIN_CYCLES - 1);
    localparam logic [EW-1:0] SAT_V  = EW'(MAX_EDGES + 1);
    localparam logic [EW-1:0] MIN_V  = EW'(MIN_EDGES);
    localparam logic [EW-1:0] MAX_V  = EW'(MAX_EDGES);

    logic [CW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] edge_nxt;
    logic          at_end;

    always_comb begin
        edge_nxt = edge_cnt;
        if (edge_pulse && (edge_cnt != SAT_V)) begin
            edge_nxt = edge_cnt + 1'b1;
        end
    end

    assign at_end = (win_cnt == LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else if (restart || !run) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else if (at_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= edge_nxt;
        end
    end

    always_comb begin
        verdict.done = run && !restart && at_end;
        verdict.slow = (edge_nxt < MIN_V);
        verdict.fast = (edge_nxt > MAX_V);
    end
endmodule

// File: rtl/extclk_fsm.sv
module extclk_fsm
    import extclk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mon_en,
    input  logic         stat_rd,
    input  win_verdict_t verdict,
    output logic         fail_active,
    output logic         win_restart,
    output logic         fail_stat
);
    mon_state_t state;
    mon_state_t state_nxt;
    logic       bad_window;
    logic       fail_set;

    assign bad_window = verdict.done && (verdict.slow || verdict.fast);

    always_comb begin
        state_nxt = state;
        if (!mon_en) begin
            state_nxt = MON_IDLE;
        end else begin
            unique case (state)
                MON_IDLE:    state_nxt = MON_WATCH;
                MON_WATCH:   if (bad_window) state_nxt = MON_FAIL;
                MON_FAIL:    if (stat_rd) state_nxt = MON_CONFIRM;
                MON_CONFIRM: begin
                    if (bad_window)        state_nxt = MON_FAIL;
                    else if (verdict.done) state_nxt = MON_WATCH;
                end
                default:     state_nxt = MON_IDLE;
            endcase
        end
    end

    assign fail_set = mon_en && bad_window &&
                      ((state == MON_WATCH) || (state == MON_CONFIRM));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= MON_IDLE;
            fail_stat <= 1'b0;
        end else begin
            state <= state_nxt;
            if (fail_set) begin
                fail_stat <= 1'b1;
            end else if (stat_rd) begin
                fail_stat <= 1'b0;
            end
        end
    end

    always_comb begin
        fail_active = 1'b0;
        win_restart = 1'b0;
        unique case (state)
            MON_IDLE:    win_restart = 1'b1;
            MON_WATCH:   ;
            MON_FAIL: begin
                fail_active = 1'b1;
                win_restart = stat_rd;
            end
            MON_CONFIRM: fail_active = 1'b1;
            default:     win_restart = 1'b1;
        endcase
    end
endmodule

// File: rtl/extclk_route.sv
module extclk_route #(
    parameter int N_CH = 2
) (
    input  logic            fail_active,
    input  logic            edge_pulse,
    input  logic [N_CH-1:0] on_bit,
    input  logic [N_CH-1:0] pwm_wave,
    output logic [N_CH-1:0] ch_out,
    output logic            ext_tick
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch_out[g] = fail_active ? on_bit[g] : pwm_wave[g];
    end

    assign ext_tick = edge_pulse & ~fail_active;
endmodule

// File: rtl/extclk_monitor.sv
module extclk_monitor
    import extclk_pkg::*;
#(
    parameter int N_CH        = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYCLES  = 64,
    parameter int MIN_EDGES   = 4,
    parameter int MAX_EDGES   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_clk,
    input  logic            ext_sel,
    input  logic            pwm_on,
    input  logic            stat_rd,
    input  logic [N_CH-1:0] on_bit,
    input  logic [N_CH-1:0] pwm_wave,
    output logic            ext_tick,
    output logic [N_CH-1:0] ch_out,
    output logic            fault_n,
    output logic            clk_fail_stat
);
    logic         mon_en;
    logic         edge_pulse;
    logic         fail_active;
    logic         win_restart;
    win_verdict_t verdict;

    assign mon_en = ext_sel & pwm_on;

    extclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .rise     (edge_pulse)
    );

    extclk_window #(
        .WIN_CYCLES (WIN_CYCLES),
        .MIN_EDGES  (MIN_EDGES),
        .MAX_EDGES  (MAX_EDGES)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (mon_en),
        .restart    (win_restart),
        .edge_pulse (edge_pulse),
        .verdict    (verdict)
    );

    extclk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mon_en      (mon_en),
        .stat_rd     (stat_rd),
        .verdict     (verdict),
        .fail_active (fail_active),
        .win_restart (win_restart),
        .fail_stat   (clk_fail_stat)
    );

    extclk_route #(.N_CH(N_CH)) u_route (
        .fail_active (fail_active),
        .edge_pulse  (edge_pulse),
        .on_bit      (on_bit),
        .pwm_wave    (pwm_wave),
        .ch_out      (ch_out),
        .ext_tick    (ext_tick)
    );

    assign fault_n = ~fail_active;
endmodule

// File: rtl/extclk_monitor_chk.sv
module extclk_monitor_chk #(
    parameter int N_CH = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_sel,
    input logic            pwm_on,
    input logic            stat_rd,
    input logic [N_CH-1:0] on_bit,
    input logic [N_CH-1:0] pwm_wave,
    input logic            ext_tick,
    input logic [N_CH-1:0] ch_out,
    input logic            fault_n,
    input logic            clk_fail_stat
);
    AST_DISABLED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_sel && pwm_on) |=> fault_n); // R1

    AST_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> !ext_tick); // R5

    AST_FAIL_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> clk_fail_stat); // R6

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_fail_stat && !stat_rd) |=> clk_fail_stat); // R6

    AST_CH_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (ch_out == on_bit)); // R7

    AST_CH_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n |-> (ch_out == pwm_wave)); // R7

    AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_n) && $past(ext_sel && pwm_on)) |-> !clk_fail_stat); // R8
endmodule

bind extclk_monitor extclk_monitor_chk #(.N_CH(N_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_sel       (ext_sel),
    .pwm_on        (pwm_on),
    .stat_rd       (stat_rd),
    .on_bit        (on_bit),
    .pwm_wave      (pwm_wave),
    .ext_tick      (ext_tick),
    .ch_out        (ch_out),
    .fault_n       (fault_n),
    .clk_fail_stat (clk_fail_stat)
);

// File: tb/sim_extclk_monitor.sv
`timescale 1ns/1ps
module sim_extclk_monitor;
    localparam int WIN = 64;

    typedef struct packed {
        logic [7:0] per;
        logic       sel;
        logic       pwm;
        logic       rd;
        logic       exp_fn;
        logic       exp_st;
    } vec_t;

    // per: external period in system cycles (0 = stopped); 8 gives ~8 edges per
    // window (in range 4..12), 32 gives ~2 (slow), 2 gives ~32 (fast)
    localparam vec_t VECS [12] = '{
        '{8'd8,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 in range
        '{8'd32, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 slow
        '{8'd8,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R8 good clock, no read
        '{8'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R9 read, recovers
        '{8'd2,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R3 fast
        '{8'd2,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R9 read while still bad
        '{8'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R9 recover
        '{8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 stopped clock
        '{8'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R9 recover
        '{8'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R1 internal source
        '{8'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R1 pwm off
        '{8'd8,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0}   // R4 in range again
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       ext_sel = 1'b0;
    logic       pwm_on = 1'b0;
    logic       stat_rd = 1'b0;
    logic [1:0] on_bit = 2'b10;
    logic [1:0] pwm_wave = 2'b01;
    logic       ext_tick;
    logic [1:0] ch_out;
    logic       fault_n;
    logic       clk_fail_stat;

    int per = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    extclk_monitor u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_clk       (ext_clk),
        .ext_sel       (ext_sel),
        .pwm_on        (pwm_on),
        .stat_rd       (stat_rd),
        .on_bit        (on_bit),
        .pwm_wave      (pwm_wave),
        .ext_tick      (ext_tick),
        .ch_out        (ch_out),
        .fault_n       (fault_n),
        .clk_fail_stat (clk_fail_stat)
    );

    always begin
        if (per == 0) begin
            ext_clk = 1'b0;
            @(negedge clk);
        end else begin
            ext_clk = 1'b1;
            repeat (per / 2) @(negedge clk);
            ext_clk = 1'b0;
            repeat (per - per / 2) @(negedge clk);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic read_strobe();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ext_tick) c++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "fault_n", int'(fault_n), 1);
        check("R10", "stat", int'(clk_fail_stat), 0);
        check("R10", "ch_out", int'(ch_out), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 12; v++) begin
            per = int'(VECS[v].per);
            ext_sel = VECS[v].sel;
            pwm_on = VECS[v].pwm;
            if (VECS[v].rd) read_strobe();
            repeat (4 * WIN) @(negedge clk);
            check("R2/R3/R4/R8/R9 vector", "fault_n", int'(fault_n), int'(VECS[v].exp_fn));
            check("R6 vector", "stat", int'(clk_fail_stat), int'(VECS[v].exp_st));
            check("R7 vector", "ch_out", int'(ch_out),
                  VECS[v].exp_fn ? int'(pwm_wave) : int'(on_bit));
        end

        // R5: ticks pass while healthy
        count_ticks(2 * WIN, ticks);
        check("R5", "ticks healthy>0", int'(ticks > 0), 1);

        // R5/R7: failure suppresses ticks, channels follow on bits
        per = 32;
        repeat (4 * WIN) @(negedge clk);
        check("R2", "fault_n slow", int'(fault_n), 0);
        count_ticks(2 * WIN, ticks);
        check("R5", "ticks in fault", ticks, 0);
        on_bit = 2'b11;
        @(negedge clk);
        check("R7", "ch_out follows on_bit", int'(ch_out), 3);

        // R8: good clock without read keeps fault
        per = 8;
        repeat (3 * WIN) @(negedge clk);
        check("R8", "fault_n no read", int'(fault_n), 0);
        // R9: full confirmation window after read
        read_strobe();
        check("R6", "stat cleared by read", int'(clk_fail_stat), 0);
        repeat (WIN - 8) @(negedge clk);
        check("R9", "fault_n mid confirm", int'(fault_n), 0);
        repeat (WIN) @(negedge clk);
        check("R9", "fault_n released", int'(fault_n), 1);

        // R1/R6: disabling during fault releases fault_n, keeps sticky bit
        per = 0;
        repeat (4 * WIN) @(negedge clk);
        check("R2", "fault_n stopped", int'(fault_n), 0);
        pwm_on = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "fault_n disabled", int'(fault_n), 1);
        check("R1", "ch_out pwm when disabled", int'(ch_out), int'(pwm_wave));
        check("R6", "stat kept while disabled", int'(clk_fail_stat), 1);
        repeat (4 * WIN) @(negedge clk);
        check("R1", "no new fault disabled", int'(fault_n), 1);
        read_strobe();
        check("R6", "stat cleared", int'(clk_fail_stat), 0);

        finish_run();
    end
endmodule